// File: doc/BRIEF.md
# Interrupt Pending and Gating Unit

This block keeps the interrupt-status bits of a processor core and decides whether an interrupt may be taken. Each source owns one status bit. A level-change event on the request port names a source and gives its new level. Two low bits can also be written by software as software interrupts. A local enable mask selects which status bits count as pending.

Two separate results are produced. The wake output rises whenever any masked status bit is set, whatever the global enable and debug state are. A halted core uses it to resume. The take request is stricter: it also needs the global enable set and the debug-state flag clear. Beside it, the block reports the highest-numbered masked pending source with a valid flag. The take request, index and valid flag are registered and so appear one clock after the state that produces them. Mask, global enable and debug flag are simple write-enabled registers with read-back ports.

Top module: `irq_gate_unit`

## Requirements
- R1: A level event (`line_vld`=1) whose index is below NUM_SRC (13) sets that status bit to 1 when `line_lvl` is 1 and clears it when `line_lvl` is 0, at the next clock edge.
- R2: A level event whose index is NUM_SRC or higher (13, 14 or 15 with the default 4-bit index) changes no status bit.
- R3: A software write (`swi_wr_en`=1) loads status bits 0 and 1 from `swi_wr_data` and leaves bits 2 and up unchanged. When a level event targets bit 0 or 1 in the same cycle, the software write wins.
- R4: A synchronous reset (`rst_n`=0 at a clock edge) clears all status bits, the mask, the global enable and the debug flag, and forces `take_req`, `take_idx_vld` and `take_idx` to 0.
- R5: `wake` is 1 exactly when the bitwise AND of status and mask is nonzero, in the same cycle as those registers. It does not depend on the global enable or the debug flag.
- R6: `take_req` is 1 only if, one cycle earlier, the global enable was 1, the debug flag was 0 and the masked pending set was nonzero.
- R7: `take_idx` gives the highest-numbered bit set in the masked pending set of the previous cycle.
- R8: `take_req`, `take_idx` and `take_idx_vld` change one clock after the status, mask, enable or debug change that causes them.
- R9: `take_idx_vld` is 0 and `take_idx` reads 0 when the masked pending set of the previous cycle was zero.
- R10: The mask, global enable and debug flag load from their write-data inputs when their write enables are 1. They read back on `mask_rd`, `gie_rd` and `dbg_rd` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_vld | input | 1 | Level event present this cycle |
| line_idx | input | IDX_W (4) | Source index of the level event |
| line_lvl | input | 1 | New level of the named source |
| swi_wr_en | input | 1 | Software-interrupt bits write enable |
| swi_wr_data | input | SW_BITS (2) | New values of status bits 0 and 1 |
| mask_wr_en | input | 1 | Local enable mask write enable |
| mask_wr_data | input | NUM_SRC (13) | New local enable mask |
| gie_wr_en | input | 1 | Global enable write enable |
| gie_wr_data | input | 1 | New global enable |
| dbg_wr_en | input | 1 | Debug-state flag write enable |
| dbg_wr_data | input | 1 | New debug-state flag |
| status_rd | output | NUM_SRC (13) | Current status bits |
| mask_rd | output | NUM_SRC (13) | Current local enable mask |
| gie_rd | output | 1 | Current global enable |
| dbg_rd | output | 1 | Current debug-state flag |
| wake | output | 1 | Masked pending set nonzero (ungated) |
| take_req | output | 1 | Registered request to take an interrupt |
| take_idx | output | IDX_W (4) | Registered highest pending source index |
| take_idx_vld | output | 1 | Registered qualifier of take_idx |

## Verification
The embedded properties check four things on every cycle: a level event within range lands on its bit, an out-of-range event leaves status alone, a take request never appears without global enable, clear debug state and a pending source, and a reported index is the top bit of the previous masked set, with a valid index always following a wake. The bench scenarios show the parts a property cannot: reset values, wake staying high while taking is blocked, the one-cycle lag of the registered outputs against the same-cycle wake, the software write winning a same-cycle collision, and the priority choice across several mask and status patterns.

// File: rtl/igu_pkg.sv
// Package: shared defaults and the control-register record of the
// interrupt gating unit. Assumes nothing beyond IEEE 1800-2017.
package igu_pkg;

    localparam int IGU_NUM_SRC_DEF = 13;
    localparam int IGU_SW_BITS_DEF = 2;

    // Global controls that gate taking an interrupt
    typedef struct packed {
        logic gie;
        logic dbg;
    } igu_ctrl_t;

endpackage

// File: rtl/igu_status.sv
// Module: igu_status
// Holds the per-source status bits. A level event writes one bit; out-of-
// range indices match no bit and so change nothing. The lowest SW_BITS bits
// can also be written by software, and software wins a same-cycle clash.
// Assumes a synchronous active-low reset that clears every bit.
module igu_status #(
    parameter int NUM_SRC = 13,
    parameter int SW_BITS = 2,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_vld,
    input  logic [IDX_W-1:0]   evt_idx,
    input  logic               evt_lvl,
    input  logic               sw_wr_en,
    input  logic [SW_BITS-1:0] sw_wr_data,
    output logic [NUM_SRC-1:0] status_q
);

    localparam logic [IDX_W:0] SRC_LIM = (IDX_W+1)'(NUM_SRC);
    localparam logic [IDX_W:0] SW_LIM  = (IDX_W+1)'(SW_BITS);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        if (g < SW_BITS) begin : g_sw
            // Software-writable bit: software write first, then line event
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status_q[g] <= 1'b0;
                else if (sw_wr_en)
                    status_q[g] <= sw_wr_data[g];
                else if (evt_vld && evt_idx == IDX_W'(g))
                    status_q[g] <= evt_lvl;
            end
        end else begin : g_hw
            // Hardware-only bit: follows its line event
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status_q[g] <= 1'b0;
                else if (evt_vld && evt_idx == IDX_W'(g))
                    status_q[g] <= evt_lvl;
            end
        end
    end

    AST_EVT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && ({1'b0, evt_idx} < SRC_LIM) &&
         !(sw_wr_en && ({1'b0, evt_idx} < SW_LIM)))
        |=> status_q[$past(evt_idx)] == $past(evt_lvl)); // R1

    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && ({1'b0, evt_idx} >= SRC_LIM) && !sw_wr_en)
        |=> $stable(status_q)); // R2

endmodule

// File: rtl/igu_prio.sv
// Module: igu_prio
// Combinational priority search: returns the highest-numbered set bit of
// the input vector and whether any bit is set. Index is 0 when none is set.
module igu_prio #(
    parameter int NUM_SRC = 13,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0] vec,
    output logic [IDX_W-1:0]   top_idx,
    output logic               any
);

    // Scan upward so that the last (highest) set bit is kept
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (vec[i])
                top_idx = IDX_W'(i);
        end
    end

    // Any-bit reduction for the valid qualifier
    always_comb any = |vec;

endmodule

// File: rtl/igu_gate.sv
// Module: igu_gate
// Registers the take decision and the selected index. Taking needs the
// global enable, a clear debug flag and a nonzero masked pending set.
// Assumes pend_vec, sel_idx and sel_any describe the same cycle.
module igu_gate #(
    parameter int NUM_SRC = 13,
    parameter int IDX_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  pend_vec,
    input  igu_pkg::igu_ctrl_t  ctrl,
    input  logic [IDX_W-1:0]    sel_idx,
    input  logic                sel_any,
    output logic                take_q,
    output logic [IDX_W-1:0]    idx_q,
    output logic                vld_q
);

    logic allow;

    // Gate: global enable on and not in debug state
    always_comb allow = ctrl.gie && !ctrl.dbg;

    // Output register stage for take, index and qualifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            idx_q  <= '0;
            vld_q  <= 1'b0;
        end else begin
            take_q <= allow && sel_any;
            idx_q  <= sel_any ? sel_idx : '0;
            vld_q  <= sel_any;
        end
    end

    AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> ($past(ctrl.gie) && !$past(ctrl.dbg) && ($past(pend_vec) != '0))); // R6

    AST_IDX_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (($past(pend_vec) >> idx_q) == NUM_SRC'(1))); // R7

    AST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |-> (idx_q == '0 && !take_q)); // R9

endmodule

// File: rtl/irq_gate_unit.sv
// Module: irq_gate_unit (top)
// Interrupt pending and gating unit. Holds status, mask, global enable and
// debug flag; drives an ungated wake, a registered take request and the
// registered index of the highest masked pending source.
// Assumes synchronous active-low reset and one clock domain.
module irq_gate_unit #(
    parameter int NUM_SRC = igu_pkg::IGU_NUM_SRC_DEF,
    parameter int SW_BITS = igu_pkg::IGU_SW_BITS_DEF,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_vld,
    input  logic [IDX_W-1:0]   line_idx,
    input  logic               line_lvl,
    input  logic               swi_wr_en,
    input  logic [SW_BITS-1:0] swi_wr_data,
    input  logic               mask_wr_en,
    input  logic [NUM_SRC-1:0] mask_wr_data,
    input  logic               gie_wr_en,
    input  logic               gie_wr_data,
    input  logic               dbg_wr_en,
    input  logic               dbg_wr_data,
    output logic [NUM_SRC-1:0] status_rd,
    output logic [NUM_SRC-1:0] mask_rd,
    output logic               gie_rd,
    output logic               dbg_rd,
    output logic               wake,
    output logic               take_req,
    output logic [IDX_W-1:0]   take_idx,
    output logic               take_idx_vld
);

    logic [NUM_SRC-1:0]  status_q;
    logic [NUM_SRC-1:0]  mask_q;
    igu_pkg::igu_ctrl_t  ctrl_q;
    logic [NUM_SRC-1:0]  pend;
    logic [IDX_W-1:0]    sel_idx;
    logic                sel_any;

    igu_status #(.NUM_SRC(NUM_SRC), .SW_BITS(SW_BITS), .IDX_W(IDX_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_vld    (line_vld),
        .evt_idx    (line_idx),
        .evt_lvl    (line_lvl),
        .sw_wr_en   (swi_wr_en),
        .sw_wr_data (swi_wr_data),
        .status_q   (status_q)
    );

    // Control registers: mask, global enable and debug flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (mask_wr_en) mask_q     <= mask_wr_data;
            if (gie_wr_en)  ctrl_q.gie <= gie_wr_data;
            if (dbg_wr_en)  ctrl_q.dbg <= dbg_wr_data;
        end
    end

    // Masked pending set
    always_comb pend = status_q & mask_q;

    igu_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .vec     (pend),
        .top_idx (sel_idx),
        .any     (sel_any)
    );

    igu_gate #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_vec (pend),
        .ctrl     (ctrl_q),
        .sel_idx  (sel_idx),
        .sel_any  (sel_any),
        .take_q   (take_req),
        .idx_q    (take_idx),
        .vld_q    (take_idx_vld)
    );

    // Read-back and ungated wake
    always_comb begin
        status_rd = status_q;
        mask_rd   = mask_q;
        gie_rd    = ctrl_q.gie;
        dbg_rd    = ctrl_q.dbg;
        wake      = sel_any;
    end

    AST_VLD_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_idx_vld |-> $past(wake)); // R8

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> mask_rd == $past(mask_wr_data)); // R10

endmodule

// File: tb/tb_irq_gate_unit.sv
module tb_irq_gate_unit;

    localparam int N  = 13;
    localparam int SW = 2;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_vld = 1'b0;
    logic [IW-1:0] line_idx = '0;
    logic          line_lvl = 1'b0;
    logic          swi_wr_en = 1'b0;
    logic [SW-1:0] swi_wr_data = '0;
    logic          mask_wr_en = 1'b0;
    logic [N-1:0]  mask_wr_data = '0;
    logic          gie_wr_en = 1'b0;
    logic          gie_wr_data = 1'b0;
    logic          dbg_wr_en = 1'b0;
    logic          dbg_wr_data = 1'b0;
    logic [N-1:0]  status_rd, mask_rd;
    logic          gie_rd, dbg_rd, wake, take_req, take_idx_vld;
    logic [IW-1:0] take_idx;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_gate_unit dut (
        .clk(clk), .rst_n(rst_n),
        .line_vld(line_vld), .line_idx(line_idx), .line_lvl(line_lvl),
        .swi_wr_en(swi_wr_en), .swi_wr_data(swi_wr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .gie_wr_en(gie_wr_en), .gie_wr_data(gie_wr_data),
        .dbg_wr_en(dbg_wr_en), .dbg_wr_data(dbg_wr_data),
        .status_rd(status_rd), .mask_rd(mask_rd), .gie_rd(gie_rd), .dbg_rd(dbg_rd),
        .wake(wake), .take_req(take_req), .take_idx(take_idx), .take_idx_vld(take_idx_vld)
    );

    // Vector: [34:22] mask, [21:9] status, [8] gie, [7] dbg,
    //         [6] take, [5] wake, [4] valid, [3:0] index
    localparam int NV = 8;
    localparam logic [34:0] VECS [NV] = '{
        {13'h1FFF, 13'h0004, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2},
        {13'h1FFF, 13'h1004, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd12},
        {13'h0FFF, 13'h1004, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2},
        {13'h0003, 13'h1FFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0},
        {13'h1FFF, 13'h0080, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7},
        {13'h1FFF, 13'h0080, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7},
        {13'h0050, 13'h0070, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6},
        {13'h0001, 13'h0001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic line_evt(input int idx, input bit lvl);
        line_vld = 1'b1; line_idx = IW'(idx); line_lvl = lvl;
        tick();
        line_vld = 1'b0;
    endtask

    task automatic load_status(input logic [N-1:0] pat);
        for (int i = 0; i < N; i++) line_evt(i, pat[i]);
    endtask

    task automatic write_ctrl(input logic [N-1:0] m, input bit g, input bit d);
        mask_wr_en = 1'b1; mask_wr_data = m;
        gie_wr_en = 1'b1; gie_wr_data = g;
        dbg_wr_en = 1'b1; dbg_wr_data = d;
        tick();
        mask_wr_en = 1'b0; gie_wr_en = 1'b0; dbg_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) tick();
        // R4: reset state
        check("R4 status", int'(status_rd), 0);
        check("R4 mask", int'(mask_rd), 0);
        check("R4 gie/dbg", int'({gie_rd, dbg_rd}), 0);
        check("R4 outputs", int'({wake, take_req, take_idx_vld, take_idx}), 0);
        rst_n = 1'b1;
        tick();

        // Vector walk: R5 R6 R7 R9 R10
        for (int v = 0; v < NV; v++) begin
            write_ctrl(VECS[v][34:22], VECS[v][8], VECS[v][7]);
            check("R10 mask readback", int'(mask_rd), int'(VECS[v][34:22]));
            check("R10 gie/dbg readback", int'({gie_rd, dbg_rd}), int'(VECS[v][8:7]));
            load_status(VECS[v][21:9]);
            check("R1 status", int'(status_rd), int'(VECS[v][21:9]));
            check("R5 wake", int'(wake), int'(VECS[v][5]));
            tick();
            check("R6 take", int'(take_req), int'(VECS[v][6]));
            check("R9 valid", int'(take_idx_vld), int'(VECS[v][4]));
            check("R7 index", int'(take_idx), int'(VECS[v][3:0]));
        end

        // R8: latency. Start with pending zero, then open the mask
        write_ctrl(13'h0000, 1'b1, 1'b0);
        load_status(13'h0210);
        tick();
        check("R8 idle take", int'(take_req), 0);
        mask_wr_en = 1'b1; mask_wr_data = 13'h1FFF;
        tick();
        mask_wr_en = 1'b0;
        check("R5 wake same cycle", int'(wake), 1);
        check("R8 take lags one cycle", int'(take_req), 0);
        tick();
        check("R8 take after one cycle", int'(take_req), 1);
        check("R7 index 9", int'(take_idx), 9);

        // R2: out-of-range indices ignored
        line_evt(13, 1'b1);
        line_evt(15, 1'b1);
        line_evt(14, 1'b0);
        check("R2 status unchanged", int'(status_rd), 'h0210);

        // R1: level 0 clears a bit
        line_evt(9, 1'b0);
        check("R1 clear bit 9", int'(status_rd), 'h0010);

        // R3: software write, collision with line event on bit 1
        swi_wr_en = 1'b1; swi_wr_data = 2'b10;
        line_vld = 1'b1; line_idx = 4'd1; line_lvl = 1'b0;
        tick();
        swi_wr_en = 1'b0; line_vld = 1'b0;
        check("R3 sw wins collision", int'(status_rd), 'h0012);
        swi_wr_en = 1'b1; swi_wr_data = 2'b01;
        tick();
        swi_wr_en = 1'b0;
        check("R3 sw write keeps upper bits", int'(status_rd), 'h0011);

        // R9: pending cleared gives valid 0 and index 0
        write_ctrl(13'h0000, 1'b1, 1'b0);
        tick();
        check("R9 valid low", int'({take_idx_vld, take_idx}), 0);
        check("R5 wake low", int'(wake), 0);

        // R4: reset mid-run
        write_ctrl(13'h1FFF, 1'b1, 1'b1);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check("R4 mid reset status", int'(status_rd), 0);
        check("R4 mid reset mask/ctrl", int'({mask_rd, gie_rd, dbg_rd}), 0);
        check("R4 mid reset take", int'({take_req, take_idx_vld, take_idx}), 0);

        finish_run();
    end

endmodule